// File: doc/BRIEF.md
# Jump and Subroutine-Call Target Sequencer

This block works out the next program counter for jump and subroutine-call operations of a small byte-wide processor core. The surrounding core gives it the two operand bytes of the instruction (a low byte and a high byte), a two-bit addressing-mode code, a call/jump flag, the return address and the current stack pointer. The block then runs a short sequence over a single byte-wide memory port and hands back the new program counter and stack pointer.

For a call, the return address goes onto a descending stack that sits in a fixed memory page. The high byte is written first, then the low byte, and the stack pointer moves down after each write. Only after both writes does the target get resolved. Four ways of forming the target are supported:
- the operand bytes used directly;
- a pointer read from the full operand address;
- a pointer read from page zero;
- a call-only mode that pins the high target byte to the top page.

The block makes at most one memory access per cycle. It marks completion with a one-cycle `done` pulse.

Top module: `jsq_top`

## Requirements
- R1: While and after reset, `pc_out` is 0x0000, `sp_out` is 0xFF, and `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: Mode code 0 (absolute) loads `pc_out` with {adh, adl}. No memory read takes place.
- R3: Mode code 1 (indirect) reads the low target byte from address {adh, adl} and the high target byte from {adh, adl+1}. The +1 wraps inside the same page, so adl = 0xFF takes the high byte from {adh, 0x00}.
- R4: Mode code 2 (page-zero indirect) reads the low target byte from {0x00, adl} and the high target byte from {0x00, adl+1}. The +1 wraps inside page zero.
- R5: Mode code 3 on a call loads `pc_out` with {0xFF, adl}. On a jump, mode code 3 behaves exactly like mode code 0.
- R6: A call makes exactly two writes, in this order:
  - `ret_pc[15:8]` to {0x01, sp_in};
  - `ret_pc[7:0]` to {0x01, sp_in-1}.
  
  It then leaves `sp_out` = sp_in-2. All stack-pointer arithmetic wraps modulo 256.
- R7: A jump makes no memory write and leaves `sp_out` equal to `sp_in`.
- R8: The memory port makes at most one access per cycle. Read data is taken on `mem_rdata` in the cycle after the one in which `mem_rd` was high.
- R9: `done` is high for exactly one cycle. The latency is counted in rising edges, starting with the edge that accepts `start` and ending with the edge after which `done` is high. It equals 2, plus 2 for a call, plus 2 for modes 1 and 2.
- R10: `start` is ignored while `busy` is high. Operand, mode and stack inputs presented with such a `start` have no effect on the result.
- R11: `pc_out` and `sp_out` hold their values between operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| is_call | input | 1 | 1 = subroutine call, 0 = jump |
| mode | input | 2 | 0 absolute, 1 indirect, 2 page-zero indirect, 3 top-page (call) |
| adl | input | 8 | Low operand byte |
| adh | input | 8 | High operand byte |
| ret_pc | input | 16 | Return address pushed by a call |
| sp_in | input | 8 | Stack pointer at the start of the operation |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe, data returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| pc_out | output | 16 | Resolved program counter |
| sp_out | output | 8 | Stack pointer after the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when `pc_out` is valid |

## Verification
The sweep covers every call/jump and mode pairing. Operand low bytes sit at 0x00, 0x7F and 0xFF, and stack pointers at 0x00, 0x01 and 0xFF, so the page wrap of pointer reads and the modulo-256 wrap of the stack pointer are both exercised.
- A design that carried adl+1 into the high address byte would fetch the high target byte from the wrong page when adl is 0xFF.
- A design that pushed the two return bytes in the opposite order would write the wrong byte to each stack address.
- A design that decoded mode 3 on a jump would force the high byte to 0xFF where the operand byte is expected.

A stray `start` with altered operands is raised mid-operation. A design that accepted it would produce a wrong target, stack pointer or cycle count.

// File: rtl/jsq_pkg.sv
package jsq_pkg;

  typedef enum logic [1:0] {
    MODE_ABS = 2'd0,
    MODE_IND = 2'd1,
    MODE_ZPI = 2'd2,
    MODE_TOP = 2'd3
  } jmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_FETCH_LO,
    ST_FETCH_HI,
    ST_TAKE_HI,
    ST_DIRECT
  } jstate_e;

  function automatic logic needs_fetch(jmode_e m);
    return (m == MODE_IND) || (m == MODE_ZPI);
  endfunction

endpackage

// File: rtl/jsq_ptr_unit.sv
module jsq_ptr_unit
  import jsq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  jmode_e              mode_q,
  input  logic [BYTE_W-1:0]   adl_q,
  input  logic [BYTE_W-1:0]   adh_q,
  input  logic                hi_sel,
  output logic [ADDR_W-1:0]   ptr_addr
);

  logic [BYTE_W-1:0] page;
  logic [BYTE_W-1:0] offs;

  // page is never carried into: the +1 wraps in the low byte
  always_comb begin
    page     = (mode_q == MODE_ZPI) ? '0 : adh_q;
    offs     = adl_q + BYTE_W'(hi_sel);
    ptr_addr = {page, offs};
  end

endmodule

// File: rtl/jsq_stack.sv
module jsq_stack #(
  parameter int                BYTE_W     = 8,
  parameter logic [BYTE_W-1:0] STACK_PAGE = 'h01,
  parameter logic [BYTE_W-1:0] RESET_SP   = '1,
  localparam int               ADDR_W     = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [BYTE_W-1:0]  load_val,
  input  logic               dec,
  output logic [BYTE_W-1:0]  sp,
  output logic [ADDR_W-1:0]  push_addr
);

  always_ff @(posedge clk) begin
    if (rst)       sp <= RESET_SP;
    else if (load) sp <= load_val;
    else if (dec)  sp <= sp - BYTE_W'(1);
  end

  assign push_addr = {STACK_PAGE, sp};

endmodule

// File: rtl/jsq_ctrl.sv
module jsq_ctrl
  import jsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       is_call,
  input  logic [1:0] mode,
  output jstate_e    st,
  output logic       call_q,
  output jmode_e     mode_q,
  output logic       busy,
  output logic       accept
);

  jstate_e st_nx;
  jmode_e  mode_in;

  assign mode_in = jmode_e'(mode);
  assign busy    = (st != ST_IDLE);
  assign accept  = start && !busy;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:
        if (start) begin
          if (is_call)                  st_nx = ST_PUSH_HI;
          else if (needs_fetch(mode_in)) st_nx = ST_FETCH_LO;
          else                          st_nx = ST_DIRECT;
        end
      ST_PUSH_HI:  st_nx = ST_PUSH_LO;
      ST_PUSH_LO:  st_nx = needs_fetch(mode_q) ? ST_FETCH_LO : ST_DIRECT;
      ST_FETCH_LO: st_nx = ST_FETCH_HI;
      ST_FETCH_HI: st_nx = ST_TAKE_HI;
      ST_TAKE_HI:  st_nx = ST_IDLE;
      ST_DIRECT:   st_nx = ST_IDLE;
      default:     st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      call_q <= 1'b0;
      mode_q <= MODE_ABS;
    end else begin
      st <= st_nx;
      if (accept) begin
        call_q <= is_call;
        mode_q <= mode_in;
      end
    end
  end

  // R6
  push_order_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PUSH_LO) |-> ($past(st) == ST_PUSH_HI));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && st != ST_TAKE_HI && st != ST_DIRECT) |=> busy);

endmodule

// File: rtl/jsq_top.sv
module jsq_top
  import jsq_pkg::*;
#(
  parameter int                BYTE_W     = 8,
  parameter logic [BYTE_W-1:0] STACK_PAGE = 'h01,
  parameter logic [BYTE_W-1:0] TOP_PAGE   = '1,
  parameter logic [BYTE_W-1:0] RESET_SP   = '1,
  parameter logic [2*BYTE_W-1:0] RESET_PC = '0,
  localparam int               ADDR_W     = 2 * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               is_call,
  input  logic [1:0]         mode,
  input  logic [BYTE_W-1:0]  adl,
  input  logic [BYTE_W-1:0]  adh,
  input  logic [ADDR_W-1:0]  ret_pc,
  input  logic [BYTE_W-1:0]  sp_in,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [BYTE_W-1:0]  mem_wdata,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic [ADDR_W-1:0]  pc_out,
  output logic [BYTE_W-1:0]  sp_out,
  output logic               busy,
  output logic               done
);

  jstate_e            st;
  jmode_e             mode_q;
  logic               call_q;
  logic               accept;
  logic [BYTE_W-1:0]  adl_q, adh_q, lo_q;
  logic [ADDR_W-1:0]  ret_q;
  logic [ADDR_W-1:0]  ptr_addr, push_addr, direct_tgt;

  jsq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .is_call(is_call),
    .mode   (mode),
    .st     (st),
    .call_q (call_q),
    .mode_q (mode_q),
    .busy   (busy),
    .accept (accept)
  );

  jsq_ptr_unit #(.BYTE_W(BYTE_W)) u_ptr (
    .mode_q  (mode_q),
    .adl_q   (adl_q),
    .adh_q   (adh_q),
    .hi_sel  (st == ST_FETCH_HI),
    .ptr_addr(ptr_addr)
  );

  jsq_stack #(
    .BYTE_W    (BYTE_W),
    .STACK_PAGE(STACK_PAGE),
    .RESET_SP  (RESET_SP)
  ) u_stack (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (sp_in),
    .dec      (mem_wr),
    .sp       (sp_out),
    .push_addr(push_addr)
  );

  // memory port: one access per state at most
  always_comb begin
    mem_wr    = (st == ST_PUSH_HI) || (st == ST_PUSH_LO);
    mem_rd    = (st == ST_FETCH_LO) || (st == ST_FETCH_HI);
    mem_addr  = mem_wr ? push_addr : (mem_rd ? ptr_addr : '0);
    mem_wdata = (st == ST_PUSH_HI) ? ret_q[ADDR_W-1:BYTE_W] : ret_q[BYTE_W-1:0];
  end

  // top-page form only exists for calls; a jump falls back to absolute
  assign direct_tgt = (call_q && mode_q == MODE_TOP) ? {TOP_PAGE, adl_q} : {adh_q, adl_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      adl_q  <= '0;
      adh_q  <= '0;
      ret_q  <= '0;
      lo_q   <= '0;
      pc_out <= RESET_PC;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        adl_q <= adl;
        adh_q <= adh;
        ret_q <= ret_pc;
      end
      unique case (st)
        ST_FETCH_HI: lo_q <= mem_rdata;
        ST_TAKE_HI: begin
          pc_out <= {mem_rdata, lo_q};
          done   <= 1'b1;
        end
        ST_DIRECT: begin
          pc_out <= direct_tgt;
          done   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R8
  one_access_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  push_dec_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> (sp_out == $past(sp_out) - BYTE_W'(1)));

  // R5
  top_page_chk: assert property (@(posedge clk) disable iff (rst)
    (done && call_q && mode_q == MODE_TOP) |-> (pc_out[ADDR_W-1:BYTE_W] == TOP_PAGE));

  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(pc_out));

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !done && !mem_rd && !mem_wr));

endmodule

// File: tb/jsq_top_test.sv
module jsq_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, is_call;
  logic [1:0]  mode;
  logic [7:0]  adl, adh, sp_in;
  logic [15:0] ret_pc;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic [15:0] pc_out;
  logic [7:0]  sp_out;
  logic        busy, done;

  int checks   = 0;
  int failures = 0;
  logic finished = 1'b0;

  // write log
  logic        log_clr;
  int          wn;
  logic [15:0] wa [4];
  logic [7:0]  wd [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  jsq_top uut (
    .clk(clk), .rst(rst), .start(start), .is_call(is_call), .mode(mode),
    .adl(adl), .adh(adh), .ret_pc(ret_pc), .sp_in(sp_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pc_out(pc_out), .sp_out(sp_out), .busy(busy), .done(done)
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  // synchronous-read memory model with a computed content
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= memf(mem_addr);
    if (log_clr) wn <= 0;
    else if (mem_wr) begin
      if (wn < 4) begin
        wa[wn] <= mem_addr;
        wd[wn] <= mem_wdata;
      end
      wn <= wn + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic c, input logic [1:0] m, input logic [7:0] l,
                        input logic [7:0] h, input logic [7:0] s, input logic stray);
    logic [15:0] ret, exp_pc;
    logic [7:0]  exp_sp;
    logic        ind;
    int          n, exp_n;
    ret = {h ^ 8'hA5, l + 8'h11};
    ind = (m == 2'd1) || (m == 2'd2);
    if (m == 2'd1)
      exp_pc = {memf({h, l + 8'd1}), memf({h, l})};
    else if (m == 2'd2)
      exp_pc = {memf({8'h00, l + 8'd1}), memf({8'h00, l})};
    else if (m == 2'd3 && c)
      exp_pc = {8'hFF, l};
    else
      exp_pc = {h, l};
    exp_sp = c ? s - 8'd2 : s;
    exp_n  = 2 + (c ? 2 : 0) + (ind ? 2 : 0);

    @(negedge clk);
    is_call = c; mode = m; adl = l; adh = h; sp_in = s; ret_pc = ret;
    start = 1'b1; log_clr = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    start = 1'b0; log_clr = 1'b0;
    while (!done && n < 40) begin
      if (stray && n == 2) begin
        // R10: altered request while busy
        start = 1'b1; is_call = ~c; mode = m + 2'd1; adl = ~l; adh = ~h;
        sp_in = s + 8'h40; ret_pc = ~ret;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == exp_n, "R9 latency", n, exp_n);
    chk(pc_out == exp_pc, (m == 2'd0) ? "R2 pc" : (m == 2'd1) ? "R3 pc" :
        (m == 2'd2) ? "R4 pc" : "R5 pc", pc_out, exp_pc);
    chk(sp_out == exp_sp, c ? "R6 sp" : "R7 sp", sp_out, exp_sp);
    if (c) begin
      chk(wn == 2, "R6 write count", wn, 2);
      chk(wa[0] == {8'h01, s} && wd[0] == ret[15:8], "R6 first push",
          {wa[0], wd[0]}, {8'h01, s, ret[15:8]});
      chk(wa[1] == {8'h01, s - 8'd1} && wd[1] == ret[7:0], "R6 second push",
          {wa[1], wd[1]}, {8'h01, s - 8'd1, ret[7:0]});
    end else begin
      chk(wn == 0, "R7 no writes", wn, 0);
    end
    if (stray) chk(1'b1 && pc_out == exp_pc, "R10 stray start ignored", pc_out, exp_pc);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    @(negedge clk);
    chk(pc_out == exp_pc && sp_out == exp_sp, "R11 hold", {pc_out, sp_out}, {exp_pc, exp_sp});
  endtask

  initial begin
    logic [7:0] lv [4];
    logic [7:0] hv [3];
    logic [7:0] sv [4];
    lv = '{8'h00, 8'h7F, 8'hFF, 8'h3A};
    hv = '{8'h00, 8'h12, 8'hFF};
    sv = '{8'h00, 8'h01, 8'h80, 8'hFF};
    rst = 1'b1; start = 1'b0; is_call = 1'b0; mode = 2'd0;
    adl = '0; adh = '0; sp_in = '0; ret_pc = '0; log_clr = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc_out == 16'h0000 && sp_out == 8'hFF, "R1 reset regs", {pc_out, sp_out}, 24'h0000FF);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 reset strobes",
        {busy, done, mem_rd, mem_wr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_rd && !mem_wr, "R1 idle after reset",
        {busy, done, mem_rd, mem_wr}, 0);
    for (int c = 0; c < 2; c++)
      for (int m = 0; m < 4; m++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 3; j++)
            for (int k = 0; k < 4; k++) begin
              logic stray_en;
              stray_en = (i == 3) && ((2 + 2*c + (((m == 1) || (m == 2)) ? 2 : 0)) >= 4);
              run_op(c[0], m[1:0], lv[i], hv[j], sv[k], stray_en);
            end
    // R8: read data returned one cycle later (page-zero pointer with wrap)
    run_op(1'b0, 2'd2, 8'hFF, 8'h55, 8'h10, 1'b0);
    chk(pc_out == {memf(16'h0000), memf(16'h00FF)}, "R8 read timing",
        pc_out, {memf(16'h0000), memf(16'h00FF)});
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule